// File: doc/BRIEF.md
# Multi-Channel Descriptor DMA Engine

This block moves data for up to sixteen channels through one shared transfer engine. Each channel keeps a transfer descriptor in a small internal store. The descriptor holds the source and destination addresses, their start values, the item size, an address-step enable for each side, a byte count per activation and a major loop count. Software fills in the descriptors through a word-wide configuration port. A channel then runs when a peripheral request line pulses, when software starts it, or when another channel hands it a link request at the end of a minor loop.

The engine serves one channel at a time, and each service is one minor loop. It loads the descriptor and repeats read/write item pairs over a 32-bit memory port until the byte count is used up. It then writes the updated addresses and count back to the store. When the major count runs out, the count is reloaded. In circular mode the addresses also return to their start values. Per-channel interrupt flags stay set until software clears them.

The memory port uses valid/ready handshakes. A request stays stable until `mem_req_ready` is seen with `mem_req_valid`. The engine has at most one read in flight and accepts the read data only while `mem_rsp_ready` is high. Writes carry no response.

Top module: `mc_dma`

## Requirements
- R1: After reset, `busy`, `mem_req_valid`, `mem_rsp_ready` and every `irq` bit are low.
- R2: The item size code is 0 for 8-bit, 1 for 16-bit and 2 for 32-bit items (3 acts as 2) and is driven on `mem_req_size`. Items sit in the low bits of the data word, and a write touches only the item's bytes.
- R3: The source and destination sides step independently after each item. The step is the item size in bytes when that side's increment bit is set, and 0 when it is clear.
- R4: One activation moves the minor byte count as a series of items, each one read from the source and then written to the destination. A byte count of 0 moves one item.
- R5: Each minor loop lowers the stored major count by one. A count of 1 or 0 ends the major loop, and the count is then reloaded from its programmed value.
- R6: At the end of a major loop with the circular bit set, both addresses return to their programmed start values. Without the circular bit, the next activation continues from the advanced addresses.
- R7: A channel's `irq` bit is set at the end of each minor loop when its minor-interrupt bit is set, and at the end of a major loop when its major-interrupt bit is set. The bit stays set until a cycle with the matching `irq_clr` bit high. A set in the same cycle as a clear wins.
- R8: Among pending channels, the highest channel number is served first. A pending request never interrupts an activation that is already running.
- R9: At the end of a minor loop with the link bit set, the channel named in the link field becomes pending.
- R10: An abort for the running channel lets the current read/write pair finish and then stops. It raises no interrupt and no link, and writes no descriptor back, so a later start begins from the last stored addresses. An abort also clears that channel's pending request.
- R11: Each memory request is held unchanged while `mem_req_valid` is high and `mem_req_ready` is low. A new request is never issued while a read response is outstanding.
- R12: A cycle with `sw_start` high makes channel `sw_ch` pending. A cycle with a bit of `hw_req` high makes that channel pending.
- R13: A configuration write with word select 0 sets the source address and its start value, and word 1 does the same for the destination. Word 2 is control: [1:0] size, [2] source increment, [3] destination increment, [4] circular, [5] major interrupt, [6] minor interrupt, [7] link enable, [11:8] link channel, [31:16] minor byte count. Word 3 [15:0] sets both the major count and its reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Descriptor word write strobe |
| cfg_ch | input | 4 | Channel to configure |
| cfg_word | input | 2 | Descriptor word select |
| cfg_wdata | input | 32 | Descriptor word value |
| hw_req | input | NUM_CH | Per-channel peripheral request pulses |
| sw_start | input | 1 | Software start strobe |
| sw_ch | input | 4 | Channel for software start |
| abort_req | input | 1 | Software abort strobe |
| abort_ch | input | 4 | Channel to abort |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 for write, 0 for read |
| mem_req_addr | output | 32 | Byte address |
| mem_req_size | output | 2 | Item size code |
| mem_req_wdata | output | 32 | Write data, item in low bits |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Engine waiting for read data |
| mem_rsp_data | input | 32 | Read data, item in low bits |
| irq | output | NUM_CH | Per-channel interrupt flags |
| irq_clr | input | NUM_CH | Per-channel interrupt clear |
| busy | output | 1 | Engine is serving a channel |

## Verification
The bench aims at these corner cases:
- A fixed source with 8-bit items. A design that stepped the fixed side, or wrote a full word for narrow items, would smear the source bytes across the destination or clobber bytes beyond the item.
- Circular wrap and non-circular continuation across back-to-back activations. Getting either wrong shows up as data landing at the wrong destination offset after the major loop ends.
- Three requests raised in the same cycle. A wrong priority shows up as a wrong order in the logged write addresses.
- An abort under random back-pressure. A design that dropped the pair in flight would show more reads than writes. One that wrote the descriptor back on abort would restart mid-buffer instead of at the start. One that still flagged completion would leave the interrupt bit set.

// File: rtl/mc_dma_pkg.sv
package mc_dma_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;
  localparam int CH_W   = 4;

  typedef struct packed {
    logic [ADDR_W-1:0] saddr;
    logic [ADDR_W-1:0] daddr;
    logic [ADDR_W-1:0] sbase;
    logic [ADDR_W-1:0] dbase;
    logic [1:0]        size;
    logic              sinc;
    logic              dinc;
    logic              circ;
    logic              ie_major;
    logic              ie_minor;
    logic              link_en;
    logic [CH_W-1:0]   link_ch;
    logic [CNT_W-1:0]  nbytes;
    logic [CNT_W-1:0]  biter;
    logic [CNT_W-1:0]  citer;
  } desc_t;

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_RD, S_RWAIT, S_WR, S_FIN
  } eng_state_t;
endpackage

// File: rtl/mc_dma_pend.sv
module mc_dma_pend
  import mc_dma_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] hw_req,
  input  logic              sw_start,
  input  logic [CH_W-1:0]   sw_ch,
  input  logic [NUM_CH-1:0] link_set,
  input  logic              take,
  input  logic [CH_W-1:0]   take_ch,
  input  logic              abort_req,
  input  logic [CH_W-1:0]   abort_ch,
  output logic [NUM_CH-1:0] pend
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_bit
    logic set_b, take_b, kill_b;
    assign set_b  = hw_req[g] | link_set[g] | (sw_start && sw_ch == CH_W'(g));
    assign take_b = take && take_ch == CH_W'(g);
    assign kill_b = abort_req && abort_ch == CH_W'(g);
    always_ff @(posedge clk) begin
      if (!rst_n) pend[g] <= 1'b0;
      else        pend[g] <= ((pend[g] & ~take_b) | set_b) & ~kill_b;
    end
  end
endmodule

// File: rtl/mc_dma_arb.sv
module mc_dma_arb
  import mc_dma_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic [NUM_CH-1:0] pend,
  output logic              grant_valid,
  output logic [CH_W-1:0]   grant_ch
);
  always_comb begin
    grant_valid = 1'b0;
    grant_ch    = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (pend[i]) begin
        grant_valid = 1'b1;
        grant_ch    = CH_W'(i);
      end
    end
  end
endmodule

// File: rtl/mc_dma_desc_ram.sv
module mc_dma_desc_ram
  import mc_dma_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CH_W-1:0]   rd_ch,
  output desc_t             rd_desc,
  input  logic              wb_en,
  input  logic [CH_W-1:0]   wb_ch,
  input  desc_t             wb_desc,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic [1:0]        cfg_word,
  input  logic [DATA_W-1:0] cfg_wdata
);
  desc_t store [NUM_CH];
  logic  unused_cfg_bits;

  assign unused_cfg_bits = ^cfg_wdata[15:12];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) store[i] <= '0;
      rd_desc <= '0;
    end else begin
      rd_desc <= store[rd_ch];
      if (wb_en) store[wb_ch] <= wb_desc;
      if (cfg_we) begin
        case (cfg_word)
          2'd0: begin
            store[cfg_ch].saddr <= cfg_wdata;
            store[cfg_ch].sbase <= cfg_wdata;
          end
          2'd1: begin
            store[cfg_ch].daddr <= cfg_wdata;
            store[cfg_ch].dbase <= cfg_wdata;
          end
          2'd2: begin
            store[cfg_ch].size     <= cfg_wdata[1:0];
            store[cfg_ch].sinc     <= cfg_wdata[2];
            store[cfg_ch].dinc     <= cfg_wdata[3];
            store[cfg_ch].circ     <= cfg_wdata[4];
            store[cfg_ch].ie_major <= cfg_wdata[5];
            store[cfg_ch].ie_minor <= cfg_wdata[6];
            store[cfg_ch].link_en  <= cfg_wdata[7];
            store[cfg_ch].link_ch  <= cfg_wdata[11:8];
            store[cfg_ch].nbytes   <= cfg_wdata[31:16];
          end
          default: begin
            store[cfg_ch].biter <= cfg_wdata[CNT_W-1:0];
            store[cfg_ch].citer <= cfg_wdata[CNT_W-1:0];
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/mc_dma_engine.sv
module mc_dma_engine
  import mc_dma_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant_valid,
  input  logic [CH_W-1:0]   grant_ch,
  output logic              take,
  input  desc_t             rd_desc,
  output logic              wb_en,
  output logic [CH_W-1:0]   wb_ch,
  output desc_t             wb_desc,
  input  logic              abort_req,
  input  logic [CH_W-1:0]   abort_ch,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [1:0]        mem_req_size,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic [NUM_CH-1:0] irq_set,
  output logic [NUM_CH-1:0] link_set,
  output logic              busy
);
  localparam logic [NUM_CH-1:0] ONE = NUM_CH'(1);

  eng_state_t        state;
  desc_t             w;
  logic [CH_W-1:0]   cur_ch;
  logic [CNT_W-1:0]  left;
  logic [DATA_W-1:0] data;
  logic              abort_q;
  logic [1:0]        eff;
  logic [CNT_W-1:0]  item_b;
  logic [ADDR_W-1:0] sstep, dstep;
  logic              last_item, major_done, active;

  assign eff        = (w.size == 2'd3) ? 2'd2 : w.size;
  assign item_b     = (eff == 2'd0) ? CNT_W'(1) : (eff == 2'd1) ? CNT_W'(2) : CNT_W'(4);
  assign sstep      = w.sinc ? ADDR_W'(item_b) : '0;
  assign dstep      = w.dinc ? ADDR_W'(item_b) : '0;
  assign last_item  = left <= item_b;
  assign major_done = w.citer <= CNT_W'(1);
  assign active     = state == S_LOAD || state == S_RD || state == S_RWAIT || state == S_WR;
  assign take       = state == S_IDLE && grant_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cur_ch  <= '0;
      w       <= '0;
      left    <= '0;
      data    <= '0;
      abort_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          abort_q <= 1'b0;
          if (grant_valid) begin
            cur_ch <= grant_ch;
            state  <= S_LOAD;
          end
        end
        S_LOAD: begin
          w     <= rd_desc;
          left  <= rd_desc.nbytes;
          state <= S_RD;
        end
        S_RD: if (mem_req_ready) state <= S_RWAIT;
        S_RWAIT: begin
          if (mem_rsp_valid) begin
            data  <= mem_rsp_data;
            state <= S_WR;
          end
        end
        S_WR: begin
          if (mem_req_ready) begin
            w.saddr <= w.saddr + sstep;
            w.daddr <= w.daddr + dstep;
            left    <= last_item ? '0 : left - item_b;
            if (abort_q)        state <= S_IDLE;
            else if (last_item) state <= S_FIN;
            else                state <= S_RD;
          end
        end
        default: state <= S_IDLE;
      endcase
      if (abort_req && abort_ch == cur_ch && active) abort_q <= 1'b1;
    end
  end

  always_comb begin
    wb_desc = w;
    if (major_done) begin
      wb_desc.citer = w.biter;
      if (w.circ) begin
        wb_desc.saddr = w.sbase;
        wb_desc.daddr = w.dbase;
      end
    end else begin
      wb_desc.citer = w.citer - CNT_W'(1);
    end
  end

  assign wb_en = state == S_FIN;
  assign wb_ch = cur_ch;

  assign irq_set  = (wb_en && (w.ie_minor || (major_done && w.ie_major))) ? (ONE << cur_ch) : '0;
  assign link_set = (wb_en && w.link_en && int'(w.link_ch) < NUM_CH) ? (ONE << w.link_ch) : '0;

  always_comb begin
    case (eff)
      2'd0:    mem_req_wdata = {24'd0, data[7:0]};
      2'd1:    mem_req_wdata = {16'd0, data[15:0]};
      default: mem_req_wdata = data;
    endcase
  end

  assign mem_req_valid = state == S_RD || state == S_WR;
  assign mem_req_we    = state == S_WR;
  assign mem_req_addr  = (state == S_WR) ? w.daddr : w.saddr;
  assign mem_req_size  = eff;
  assign mem_rsp_ready = state == S_RWAIT;
  assign busy          = state != S_IDLE;
endmodule

// File: rtl/mc_dma.sv
module mc_dma
  import mc_dma_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic [1:0]        cfg_word,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [NUM_CH-1:0] hw_req,
  input  logic              sw_start,
  input  logic [CH_W-1:0]   sw_ch,
  input  logic              abort_req,
  input  logic [CH_W-1:0]   abort_ch,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [1:0]        mem_req_size,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic [NUM_CH-1:0] irq,
  input  logic [NUM_CH-1:0] irq_clr,
  output logic              busy
);
  logic [NUM_CH-1:0] pend, irq_set, link_set;
  logic              grant_valid, take, wb_en;
  logic [CH_W-1:0]   grant_ch, wb_ch;
  desc_t             rd_desc, wb_desc;

  mc_dma_pend #(.NUM_CH(NUM_CH)) pend_i (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .sw_start(sw_start), .sw_ch(sw_ch),
    .link_set(link_set), .take(take), .take_ch(grant_ch),
    .abort_req(abort_req), .abort_ch(abort_ch), .pend(pend)
  );

  mc_dma_arb #(.NUM_CH(NUM_CH)) arb_i (
    .pend(pend), .grant_valid(grant_valid), .grant_ch(grant_ch)
  );

  mc_dma_desc_ram #(.NUM_CH(NUM_CH)) ram_i (
    .clk(clk), .rst_n(rst_n), .rd_ch(grant_ch), .rd_desc(rd_desc),
    .wb_en(wb_en), .wb_ch(wb_ch), .wb_desc(wb_desc),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_word(cfg_word), .cfg_wdata(cfg_wdata)
  );

  mc_dma_engine #(.NUM_CH(NUM_CH)) eng_i (
    .clk(clk), .rst_n(rst_n), .grant_valid(grant_valid), .grant_ch(grant_ch),
    .take(take), .rd_desc(rd_desc), .wb_en(wb_en), .wb_ch(wb_ch), .wb_desc(wb_desc),
    .abort_req(abort_req), .abort_ch(abort_ch),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_size(mem_req_size), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .irq_set(irq_set), .link_set(link_set), .busy(busy)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_irq
    always_ff @(posedge clk) begin
      if (!rst_n) irq[g] <= 1'b0;
      else        irq[g] <= (irq[g] & ~irq_clr[g]) | irq_set[g];
    end
  end
endmodule

// File: rtl/mc_dma_chk.sv
module mc_dma_chk
  import mc_dma_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [1:0]        mem_req_size,
  input logic [DATA_W-1:0] mem_req_wdata,
  input logic              mem_rsp_valid,
  input logic              mem_rsp_ready,
  input logic [NUM_CH-1:0] irq,
  input logic [NUM_CH-1:0] irq_clr
);
  logic have_data, rd_open;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_data <= 1'b0;
      rd_open   <= 1'b0;
    end else begin
      if (mem_req_valid && mem_req_ready && !mem_req_we) rd_open <= 1'b1;
      else if (mem_rsp_valid && mem_rsp_ready)          rd_open <= 1'b0;
      if (mem_rsp_valid && mem_rsp_ready)               have_data <= 1'b1;
      else if (mem_req_valid && mem_req_ready && mem_req_we) have_data <= 1'b0;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid && !mem_rsp_ready); // R1

  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_size != 2'd3); // R2

  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> have_data); // R4

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((~irq & $past(irq) & ~$past(irq_clr)) == '0)); // R7

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata)); // R11

  AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !rd_open); // R11
endmodule

bind mc_dma mc_dma_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
  .mem_req_addr(mem_req_addr), .mem_req_size(mem_req_size), .mem_req_wdata(mem_req_wdata),
  .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
  .irq(irq), .irq_clr(irq_clr)
);

// File: tb/mc_dma_tb_top.sv
module mc_dma_tb_top;
  localparam int NCH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_ch = '0;
  logic [1:0]  cfg_word = '0;
  logic [31:0] cfg_wdata = '0;
  logic [NCH-1:0] hw_req = '0;
  logic        sw_start = 1'b0;
  logic [3:0]  sw_ch = '0;
  logic        abort_req = 1'b0;
  logic [3:0]  abort_ch = '0;
  logic        mem_req_valid, mem_req_we, mem_rsp_ready;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic [1:0]  mem_req_size;
  logic        rsp_v = 1'b0;
  logic [31:0] rsp_d = '0;
  logic [NCH-1:0] irq;
  logic [NCH-1:0] irq_clr = '0;
  logic        busy;

  int nchk = 0;
  int nerr = 0;

  logic [7:0]  mem [1024];
  logic [31:0] wlog [256];
  int          wcnt = 0;
  int          rcnt = 0;
  int          viol = 0;
  logic        rdy = 1'b1;
  logic        stall_en = 1'b0;
  logic [7:0]  lfsr = 8'h5A;
  logic        hold_q = 1'b0;
  logic [31:0] hold_addr = '0;
  logic        hold_we = 1'b0;

  always #2.5 clk = ~clk;
  assign mem_req_ready = rdy;

  mc_dma #(.NUM_CH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_word(cfg_word),
    .cfg_wdata(cfg_wdata), .hw_req(hw_req), .sw_start(sw_start), .sw_ch(sw_ch),
    .abort_req(abort_req), .abort_ch(abort_ch),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_size(mem_req_size), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(rsp_v), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(rsp_d),
    .irq(irq), .irq_clr(irq_clr), .busy(busy)
  );

  // memory model with optional random back-pressure
  always @(posedge clk) begin
    logic [9:0] a;
    a = mem_req_addr[9:0];
    rdy  <= stall_en ? lfsr[0] : 1'b1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (hold_q && !(mem_req_valid && mem_req_addr == hold_addr && mem_req_we == hold_we))
      viol <= viol + 1;
    hold_q    <= mem_req_valid && !mem_req_ready;
    hold_addr <= mem_req_addr;
    hold_we   <= mem_req_we;
    if (rsp_v && mem_rsp_ready) rsp_v <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        mem[a] <= mem_req_wdata[7:0];
        if (mem_req_size != 2'd0) mem[a + 10'd1] <= mem_req_wdata[15:8];
        if (mem_req_size >= 2'd2) begin
          mem[a + 10'd2] <= mem_req_wdata[23:16];
          mem[a + 10'd3] <= mem_req_wdata[31:24];
        end
        wlog[wcnt % 256] <= mem_req_addr;
        wcnt <= wcnt + 1;
      end else begin
        rsp_v <= 1'b1;
        rsp_d <= {mem[a + 10'd3], mem[a + 10'd2], mem[a + 10'd1], mem[a]};
        rcnt  <= rcnt + 1;
      end
    end
  end

  function automatic logic [31:0] rd32(input int ad);
    return {mem[ad + 3], mem[ad + 2], mem[ad + 1], mem[ad]};
  endfunction

  task automatic wr32(input int ad, input logic [31:0] v);
    mem[ad] = v[7:0]; mem[ad + 1] = v[15:8]; mem[ad + 2] = v[23:16]; mem[ad + 3] = v[31:24];
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ctl(input int sz, input bit si, input bit di, input bit ci,
                                      input bit imj, input bit imn, input bit le, input int lc,
                                      input int nb);
    return {16'(nb), 4'd0, 4'(lc), le, imn, imj, ci, di, si, 2'(sz)};
  endfunction

  task automatic cfg(input int ch, input int wd, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 4'(ch); cfg_word = 2'(wd); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input int ch, input int src, input int dst, input logic [31:0] c,
                       input int cnt);
    cfg(ch, 0, 32'(src));
    cfg(ch, 1, 32'(dst));
    cfg(ch, 2, c);
    cfg(ch, 3, 32'(cnt));
  endtask

  task automatic sw_go(input int ch);
    @(negedge clk); sw_start = 1'b1; sw_ch = 4'(ch);
    @(negedge clk); sw_start = 1'b0;
  endtask

  task automatic hw_go(input logic [NCH-1:0] m);
    @(negedge clk); hw_req = m;
    @(negedge clk); hw_req = '0;
  endtask

  task automatic clr_irq(input logic [NCH-1:0] m);
    @(negedge clk); irq_clr = m;
    @(negedge clk); irq_clr = '0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    int t = 0;
    repeat (3) @(negedge clk);
    while (quiet < 4 && t < 20000) begin
      @(negedge clk);
      t++;
      if (busy) quiet = 0; else quiet++;
    end
    if (t >= 20000) check("R4 engine never went idle", 32'(busy), 32'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 busy after reset", 32'(busy), 32'd0);
    check("R1 req valid after reset", 32'(mem_req_valid), 32'd0);
    check("R1 rsp ready after reset", 32'(mem_rsp_ready), 32'd0);
    check("R1 irq after reset", 32'(irq), 32'd0);
  endtask

  task automatic t_copy32();
    int w0;
    for (int i = 0; i < 4; i++) wr32(16'h000 + 4 * i, 32'h11223344 + 32'(i) * 32'h01010101);
    setup(2, 'h000, 'h040, ctl(2, 1, 1, 0, 1, 0, 0, 0, 16), 1);
    w0 = wcnt;
    sw_go(2);
    wait_idle();
    for (int i = 0; i < 4; i++)
      check("R4 R12 R13 word copy", rd32('h040 + 4 * i), 32'h11223344 + 32'(i) * 32'h01010101);
    check("R4 write count per activation", 32'(wcnt - w0), 32'd4);
    check("R7 major irq set", 32'(irq[2]), 32'd1);
    clr_irq(16'h0004);
    @(negedge clk);
    check("R7 irq cleared", 32'(irq[2]), 32'd0);
  endtask

  task automatic t_sizes();
    mem['h080] = 8'hA5; mem['h081] = 8'h5A;
    setup(3, 'h080, 'h0A0, ctl(0, 0, 1, 0, 0, 0, 0, 0, 4), 1);
    sw_go(3);
    wait_idle();
    check("R3 fixed source bytes", rd32('h0A0), 32'hA5A5A5A5);
    check("R2 byte past block untouched", 32'(mem['h0A4]), 32'h0);
    wr32('h0C0, 32'h22221111);
    wr32('h0C4, 32'h00003333);
    setup(4, 'h0C0, 'h0E0, ctl(1, 1, 0, 0, 0, 0, 0, 0, 6), 1);
    hw_go(16'h0010);
    wait_idle();
    check("R2 R3 halfword fixed destination", rd32('h0E0), 32'h00003333);
  endtask

  task automatic t_major_circ();
    wr32('h100, 32'hAAAA0001);
    wr32('h104, 32'hBBBB0002);
    setup(5, 'h100, 'h140, ctl(2, 1, 1, 1, 1, 0, 0, 0, 4), 2);
    hw_go(16'h0020);
    wait_idle();
    check("R5 first minor data", rd32('h140), 32'hAAAA0001);
    check("R5 no irq before major end", 32'(irq[5]), 32'd0);
    hw_go(16'h0020);
    wait_idle();
    check("R5 second minor data", rd32('h144), 32'hBBBB0002);
    check("R5 R7 irq at major end", 32'(irq[5]), 32'd1);
    clr_irq(16'h0020);
    wr32('h100, 32'hCCCC0003);
    hw_go(16'h0020);
    wait_idle();
    check("R6 circular restart address", rd32('h140), 32'hCCCC0003);
    check("R5 count reloaded no irq", 32'(irq[5]), 32'd0);
    wr32('h180, 32'hEEEE0004);
    wr32('h184, 32'hFFFF0005);
    setup(6, 'h180, 'h1C0, ctl(2, 1, 1, 0, 0, 0, 0, 0, 4), 1);
    sw_go(6);
    wait_idle();
    sw_go(6);
    wait_idle();
    check("R6 first activation", rd32('h1C0), 32'hEEEE0004);
    check("R6 non-circular continues", rd32('h1C4), 32'hFFFF0005);
  endtask

  task automatic t_priority();
    int w0;
    wr32('h200, 32'h01); wr32('h204, 32'h09); wr32('h208, 32'h0E);
    setup(1,  'h200, 'h210, ctl(2, 1, 1, 0, 0, 0, 0, 0, 4), 1);
    setup(9,  'h204, 'h214, ctl(2, 1, 1, 0, 0, 0, 0, 0, 4), 1);
    setup(14, 'h208, 'h218, ctl(2, 1, 1, 0, 0, 0, 0, 0, 4), 1);
    w0 = wcnt;
    hw_go(16'h4202);
    wait_idle();
    check("R8 first served ch14", wlog[w0 % 256], 32'h218);
    check("R8 second served ch9", wlog[(w0 + 1) % 256], 32'h214);
    check("R8 third served ch1", wlog[(w0 + 2) % 256], 32'h210);
  endtask

  task automatic t_link();
    wr32('h220, 32'h77770007);
    wr32('h240, 32'h88880008);
    setup(8, 'h240, 'h250, ctl(2, 1, 1, 0, 0, 1, 0, 0, 4), 3);
    setup(7, 'h220, 'h230, ctl(2, 1, 1, 0, 0, 0, 1, 8, 4), 1);
    sw_go(7);
    wait_idle();
    check("R9 linking channel data", rd32('h230), 32'h77770007);
    check("R9 linked channel ran", rd32('h250), 32'h88880008);
    check("R7 minor irq on linked channel", 32'(irq[8]), 32'd1);
    check("R7 no irq when disabled", 32'(irq[7]), 32'd0);
    clr_irq(16'h0100);
  endtask

  task automatic t_backpressure();
    for (int i = 0; i < 4; i++) wr32('h380 + 4 * i, 32'h5000 + 32'(i));
    stall_en = 1'b1;
    setup(11, 'h380, 'h3C0, ctl(2, 1, 1, 0, 0, 0, 0, 0, 16), 1);
    sw_go(11);
    wait_idle();
    for (int i = 0; i < 4; i++) check("R11 data under stalls", rd32('h3C0 + 4 * i), 32'h5000 + 32'(i));
    check("R11 request held while not ready", 32'(viol), 32'd0);
  endtask

  task automatic t_abort();
    int w0, r0, t;
    for (int i = 0; i < 16; i++) wr32('h280 + 4 * i, 32'h9000 + 32'(i));
    stall_en = 1'b1;
    setup(10, 'h280, 'h300, ctl(2, 1, 1, 0, 1, 0, 0, 0, 64), 1);
    w0 = wcnt; r0 = rcnt;
    sw_go(10);
    t = 0;
    while (wcnt < w0 + 2 && t < 5000) begin @(negedge clk); t++; end
    abort_req = 1'b1; abort_ch = 4'd10;
    @(negedge clk);
    abort_req = 1'b0;
    wait_idle();
    check("R10 stopped early", 32'(wcnt - w0 < 16), 32'd1);
    check("R10 pair finished", 32'(wcnt - w0), 32'(rcnt - r0));
    check("R10 no irq on abort", 32'(irq[10]), 32'd0);
    stall_en = 1'b0;
    wr32('h280, 32'hCAFEF00D);
    wr32('h300, 32'h0);
    sw_go(10);
    wait_idle();
    check("R10 restart from stored start", rd32('h300), 32'hCAFEF00D);
    check("R10 restart runs full block", rd32('h33C), 32'h900F);
    check("R10 irq after full run", 32'(irq[10]), 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL R4 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_copy32();
    t_sizes();
    t_major_circ();
    t_priority();
    t_link();
    t_backpressure();
    t_abort();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule